// File: doc/BRIEF.md
# Output Stream Error Classifier Monitor

This block watches the output of a device under test that runs from its own clock, unrelated to the monitor clock. The device presents 8-bit records on a data port and raises a separate strobe when a record is ready. The monitor brings the strobe into its own clock domain and takes one record on each strobe rise. It measures the spacing between records in monitor clock cycles and checks each value against an incrementing counter pattern.

Records come in groups of eight, and a group ends when the strobe stays quiet for a programmable idle time. Every anomaly is sorted into one of four classes, and each class has its own saturating counter: a record spacing outside the allowed window, a record value that does not match, a group whose record count is not eight, and a run whose group count differs from the configured one. The monitor also drives the reset line of the device under test. A start pulse opens a run and an end pulse closes it.

Top module: `stream_err_monitor`

## Requirements
- R1: After rst_ni is released, all four error counters read 0 and dut_rst_no is high.
- R2: A run_start_i pulse clears all four counters, drives dut_rst_no low for RST_LEN cycles (the RST_LEN edges after the start edge), reloads the expected value from cfg_seed_i, and enables monitoring once dut_rst_no rises again.
- R3: One record is taken per rising strobe. It is processed at the third clock edge after the edge that first samples dut_valid_i high, with dut_data_i sampled at that edge. A strobe held high for many cycles yields one record.
- R4: A record whose value differs from the expected value increments data_err_cnt_o. The next expected value is the received value plus 1, modulo 256.
- R5: For every record except the first of a group, the spacing to the previous record in clock cycles is checked. A spacing above cfg_gap_i + cfg_margin_i, or below cfg_gap_i - cfg_margin_i, increments gap_err_cnt_o.
- R6: A group closes when no record arrives for cfg_idle_i cycles after the last one, or when the run ends. A group that closes with a record count other than 8 increments rec_err_cnt_o.
- R7: run_end_i closes any open group and stops monitoring. If the number of groups in the run (including the one it closed) differs from cfg_seqs_i, seq_err_cnt_o increments.
- R8: Strobes that arrive while monitoring is off (before the first start, during the device reset window, after a run ends) have no effect on any counter.
- R9: Each counter saturates at its all-ones value and never wraps.
- R10: A spacing of exactly cfg_gap_i + cfg_margin_i or cfg_gap_i - cfg_margin_i is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dut_valid_i | input | 1 | Record strobe from the device, asynchronous |
| dut_data_i | input | DATA_W | Record value, stable while a record is presented |
| run_start_i | input | 1 | Begin a run: reset the device, clear the counters |
| run_end_i | input | 1 | End the run and check the group count |
| cfg_gap_i | input | GAP_W | Nominal record spacing in cycles |
| cfg_margin_i | input | GAP_W | Allowed deviation from the nominal spacing |
| cfg_idle_i | input | GAP_W | Quiet time that closes a group |
| cfg_seqs_i | input | SEQ_W | Expected number of groups per run |
| cfg_seed_i | input | DATA_W | First expected record value |
| dut_rst_no | output | 1 | Active-low reset to the device |
| gap_err_cnt_o | output | CNT_W | Spacing error count |
| data_err_cnt_o | output | CNT_W | Value error count |
| rec_err_cnt_o | output | CNT_W | Group length error count |
| seq_err_cnt_o | output | CNT_W | Group count error count |

## Verification
The hardest state to reach is a run in which all four classes fire at once, including a group closed by the end pulse instead of by the idle timeout. A single scripted run does this. It uses a corrupted value followed by recovery, spacings one cycle past each edge of the window, groups of seven and nine records, and a fourth group still open when the run ends. Saturation needs dozens of faults, so the bench narrows the counters and sends a burst of back-to-back repeated values. These trip both the value and the spacing checks on every record.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int NUM_ERR = 4;

  typedef enum logic [1:0] {
    ERR_GAP  = 2'd0,
    ERR_DATA = 2'd1,
    ERR_REC  = 2'd2,
    ERR_SEQ  = 2'd3
  } err_cls_e;
endpackage

// File: rtl/smon_sync_rise.sv
module smon_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  // rise is registered: the record is used one cycle after the edge is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      rise_o <= sync_q[STAGES-1] & ~prev_q;
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/smon_sat_cnt.sv
module smon_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o)); // R9
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R2
endmodule

// File: rtl/smon_framer.sv
module smon_framer
  import smon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int GAP_W       = 16,
  parameter int SEQ_W       = 8,
  parameter int REC_PER_SEQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               end_i,
  input  logic               active_i,
  input  logic               rec_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [GAP_W-1:0]   cfg_gap_i,
  input  logic [GAP_W-1:0]   cfg_margin_i,
  input  logic [GAP_W-1:0]   cfg_idle_i,
  input  logic [SEQ_W-1:0]   cfg_seqs_i,
  input  logic [DATA_W-1:0]  cfg_seed_i,
  output logic [NUM_ERR-1:0] err_o
);
  localparam int REC_W = $clog2(REC_PER_SEQ + 1) + 1;
  localparam logic [REC_W-1:0] REC_MAX = '1;
  localparam logic [REC_W-1:0] REC_NOM = REC_W'(REC_PER_SEQ);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [SEQ_W-1:0] SEQ_MAX = '1;

  logic [GAP_W-1:0]  gap_q;
  logic [REC_W-1:0]  rec_q;
  logic [SEQ_W-1:0]  seq_q;
  logic              in_seq_q;
  logic [DATA_W-1:0] exp_q;

  logic             run_end, ev, idle_close, close, gap_bad;
  logic [GAP_W:0]   gap_ext, hi_lim, lo_test;
  logic [SEQ_W:0]   seq_tot;

  always_comb begin
    run_end    = active_i & end_i & ~start_i;
    ev         = active_i & rec_i & ~start_i & ~end_i;
    idle_close = active_i & in_seq_q & ~rec_i & ~end_i & ~start_i & (gap_q >= cfg_idle_i);
    close      = idle_close | (run_end & in_seq_q);
    gap_ext    = {1'b0, gap_q};
    hi_lim     = {1'b0, cfg_gap_i} + {1'b0, cfg_margin_i};
    lo_test    = gap_ext + {1'b0, cfg_margin_i};
    gap_bad    = (gap_ext > hi_lim) | (lo_test < {1'b0, cfg_gap_i});
    seq_tot    = {1'b0, seq_q} + {{SEQ_W{1'b0}}, in_seq_q};
    err_o           = '0;
    err_o[ERR_GAP]  = ev & in_seq_q & gap_bad;
    err_o[ERR_DATA] = ev & (data_i != exp_q);
    err_o[ERR_REC]  = close & (rec_q != REC_NOM);
    err_o[ERR_SEQ]  = run_end & (seq_tot != {1'b0, cfg_seqs_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      rec_q    <= '0;
      seq_q    <= '0;
      in_seq_q <= 1'b0;
      exp_q    <= '0;
    end else if (start_i) begin
      gap_q    <= '0;
      rec_q    <= '0;
      seq_q    <= '0;
      in_seq_q <= 1'b0;
      exp_q    <= cfg_seed_i;
    end else begin
      if (ev)                   gap_q <= GAP_W'(1);
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
      if (ev) begin
        exp_q    <= data_i + 1'b1;  // resync on the received value
        in_seq_q <= 1'b1;
        if (!in_seq_q)             rec_q <= REC_W'(1);
        else if (rec_q != REC_MAX) rec_q <= rec_q + 1'b1;
      end
      if (close) begin
        in_seq_q <= 1'b0;
        if (seq_q != SEQ_MAX) seq_q <= seq_q + 1'b1;
      end
    end
  end

  AST_GAP_ERR_ON_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[ERR_GAP] |-> (rec_i && active_i)); // R5
  AST_REC_ERR_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[ERR_REC] |=> !in_seq_q); // R6
  AST_SEQ_ERR_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[ERR_SEQ] |-> end_i); // R7
  AST_REC_OPENS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_i && active_i && !start_i && !end_i) |=> in_seq_q); // R6
endmodule

// File: rtl/stream_err_monitor.sv
module stream_err_monitor
  import smon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int GAP_W       = 16,
  parameter int SEQ_W       = 8,
  parameter int CNT_W       = 16,
  parameter int REC_PER_SEQ = 8,
  parameter int RST_LEN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dut_valid_i,
  input  logic [DATA_W-1:0] dut_data_i,
  input  logic              run_start_i,
  input  logic              run_end_i,
  input  logic [GAP_W-1:0]  cfg_gap_i,
  input  logic [GAP_W-1:0]  cfg_margin_i,
  input  logic [GAP_W-1:0]  cfg_idle_i,
  input  logic [SEQ_W-1:0]  cfg_seqs_i,
  input  logic [DATA_W-1:0] cfg_seed_i,
  output logic              dut_rst_no,
  output logic [CNT_W-1:0]  gap_err_cnt_o,
  output logic [CNT_W-1:0]  data_err_cnt_o,
  output logic [CNT_W-1:0]  rec_err_cnt_o,
  output logic [CNT_W-1:0]  seq_err_cnt_o
);
  localparam int RST_W = $clog2(RST_LEN + 1);
  localparam logic [RST_W-1:0] RST_LOAD = RST_W'(RST_LEN);

  logic               rec_rise;
  logic               active_q;
  logic [RST_W-1:0]   rst_cnt_q;
  logic [NUM_ERR-1:0] err;
  logic [CNT_W-1:0]   cnt [NUM_ERR];

  smon_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (dut_valid_i),
    .rise_o  (rec_rise)
  );

  // device reset window, monitoring enabled when it ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= '0;
      active_q  <= 1'b0;
    end else if (run_start_i) begin
      rst_cnt_q <= RST_LOAD;
      active_q  <= 1'b0;
    end else if (rst_cnt_q != '0) begin
      rst_cnt_q <= rst_cnt_q - 1'b1;
      if (rst_cnt_q == RST_W'(1)) active_q <= 1'b1;
    end else if (run_end_i) begin
      active_q  <= 1'b0;
    end
  end

  assign dut_rst_no = (rst_cnt_q == '0);

  smon_framer #(
    .DATA_W      (DATA_W),
    .GAP_W       (GAP_W),
    .SEQ_W       (SEQ_W),
    .REC_PER_SEQ (REC_PER_SEQ)
  ) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (run_start_i),
    .end_i        (run_end_i),
    .active_i     (active_q),
    .rec_i        (rec_rise),
    .data_i       (dut_data_i),
    .cfg_gap_i    (cfg_gap_i),
    .cfg_margin_i (cfg_margin_i),
    .cfg_idle_i   (cfg_idle_i),
    .cfg_seqs_i   (cfg_seqs_i),
    .cfg_seed_i   (cfg_seed_i),
    .err_o        (err)
  );

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
    smon_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (run_start_i),
      .inc_i  (err[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign gap_err_cnt_o  = cnt[ERR_GAP];
  assign data_err_cnt_o = cnt[ERR_DATA];
  assign rec_err_cnt_o  = cnt[ERR_REC];
  assign seq_err_cnt_o  = cnt[ERR_SEQ];

  AST_DUT_RST_BLOCKS_MON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dut_rst_no |-> !active_q); // R2
  AST_IDLE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (err == '0)); // R8
endmodule

// File: tb/stream_err_monitor_bench.sv
`timescale 1ns/1ps
module stream_err_monitor_bench;
  localparam int CNT_W = 5;
  localparam int SAT   = (1 << CNT_W) - 1;
  localparam int RSTL  = 4;
  localparam int G     = 20;
  localparam int M     = 2;
  localparam int IDLE  = 60;
  localparam int NSEQ  = 3;
  localparam int SEED  = 8'h10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic drv_valid = 1'b0, drv_start = 1'b0, drv_end = 1'b0;
  logic [7:0] drv_data = 8'h00;
  logic dut_rst_no;
  logic [CNT_W-1:0] c_gap, c_data, c_rec, c_seq;

  int tests = 0, failed = 0;
  bit chk_on = 0, done = 0;

  always #2 clk = ~clk;

  stream_err_monitor #(.CNT_W(CNT_W), .RST_LEN(RSTL)) u_stream_err_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .dut_valid_i(drv_valid), .dut_data_i(drv_data),
    .run_start_i(drv_start), .run_end_i(drv_end),
    .cfg_gap_i(16'(G)), .cfg_margin_i(16'(M)), .cfg_idle_i(16'(IDLE)),
    .cfg_seqs_i(8'(NSEQ)), .cfg_seed_i(8'(SEED)),
    .dut_rst_no(dut_rst_no), .gap_err_cnt_o(c_gap), .data_err_cnt_o(c_data),
    .rec_err_cnt_o(c_rec), .seq_err_cnt_o(c_seq)
  );

  task automatic check(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cyc = 0, m_rst_left = 0, m_rec = 0, m_seq = 0, m_last = 0, m_exp = 0;
  bit m_active = 0, m_in_seq = 0, m_prev = 0;
  int m_cnt [4] = '{0, 0, 0, 0};  // gap, data, rec, seq
  int ev_q [$];
  int ed_q [$];

  function automatic int sat(input int v);
    return (v >= SAT) ? SAT : v + 1;
  endfunction

  always @(posedge clk) begin
    bit a, ev_now;
    int d, gp;
    m_cyc++;
    ev_now = 0;
    d = 0;
    if (rst_ni) begin
      if (drv_valid && !m_prev) begin
        ev_q.push_back(m_cyc + 3);
        ed_q.push_back(int'(drv_data));
      end
      m_prev = drv_valid;
      if (ev_q.size() > 0 && ev_q[0] == m_cyc) begin
        ev_now = 1;
        d = ed_q.pop_front();
        void'(ev_q.pop_front());
      end
      a = m_active;
      if (drv_start) begin
        m_rst_left = RSTL; m_active = 0; m_in_seq = 0; m_rec = 0; m_seq = 0;
        m_exp = SEED;
        foreach (m_cnt[i]) m_cnt[i] = 0;
      end else begin
        if (m_rst_left > 0) begin
          m_rst_left--;
          if (m_rst_left == 0) m_active = 1;
        end
        if (a && drv_end) begin
          if (m_in_seq) begin
            if (m_rec != 8) m_cnt[2] = sat(m_cnt[2]);
            m_seq++;
            m_in_seq = 0;
          end
          if (m_seq != NSEQ) m_cnt[3] = sat(m_cnt[3]);
          m_active = 0;
        end else if (a && ev_now) begin
          if (m_in_seq) begin
            gp = m_cyc - m_last;
            if (gp > G + M || gp < G - M) m_cnt[0] = sat(m_cnt[0]);
            m_rec++;
          end else begin
            m_in_seq = 1;
            m_rec = 1;
          end
          if (d != m_exp) m_cnt[1] = sat(m_cnt[1]);
          m_exp = (d + 1) % 256;
          m_last = m_cyc;
        end else if (a && m_in_seq && (m_cyc - m_last) >= IDLE) begin
          if (m_rec != 8) m_cnt[2] = sat(m_cnt[2]);
          m_seq++;
          m_in_seq = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(int'(c_gap),  m_cnt[0], "R5 gap count vs model");
      check(int'(c_data), m_cnt[1], "R4 data count vs model");
      check(int'(c_rec),  m_cnt[2], "R6 record count vs model");
      check(int'(c_seq),  m_cnt[3], "R7 sequence count vs model");
      check(int'(dut_rst_no), (m_rst_left == 0) ? 1 : 0, "R2 device reset vs model");
    end
  end

  task automatic send(input logic [7:0] d, input int width, input int spacing);
    drv_valid = 1'b1;
    drv_data  = d;
    repeat (width) @(negedge clk);
    drv_valid = 1'b0;
    repeat (spacing - width) @(negedge clk);
  endtask

  task automatic start_run();
    drv_start = 1'b1;
    @(negedge clk);
    drv_start = 1'b0;
    check(int'(dut_rst_no), 0, "R2 device reset asserted after start");
    check(int'(c_data) + int'(c_gap) + int'(c_rec) + int'(c_seq), 0, "R2 counters cleared by start");
    repeat (10) @(negedge clk);
    check(int'(dut_rst_no), 1, "R2 device reset released");
  endtask

  task automatic end_run();
    drv_end = 1'b1;
    @(negedge clk);
    drv_end = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] nxt;
    int lens [4] = '{8, 7, 9, 8};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(c_gap), 0, "R1 gap counter at reset");
    check(int'(c_data), 0, "R1 data counter at reset");
    check(int'(c_rec), 0, "R1 rec counter at reset");
    check(int'(c_seq), 0, "R1 seq counter at reset");
    check(int'(dut_rst_no), 1, "R1 device reset released");
    chk_on = 1;

    // R8 strobes before any run are ignored
    send(8'hEE, 2, 15);
    send(8'h01, 2, 15);
    repeat (10) @(negedge clk);
    check(int'(c_data) + int'(c_gap), 0, "R8 records before start ignored");

    // clean run, boundary spacings (R10) and a long strobe (R3)
    start_run();
    nxt = 8'(SEED);
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < 8; r++) begin
        int sp, wd;
        sp = G; wd = 2;
        if (s == 1 && r == 1) sp = G + M;
        if (s == 1 && r == 2) sp = G - M;
        if (s == 2 && r == 3) wd = 10;
        if (r == 7) sp = IDLE + 20;
        send(nxt, wd, sp);
        nxt = nxt + 8'd1;
      end
    end
    end_run();
    check(int'(c_gap), 0, "R10 spacings on window edges accepted");
    check(int'(c_rec), 0, "R3 long strobe counted once");
    check(int'(c_data), 0, "R4 clean data run");
    check(int'(c_seq), 0, "R7 correct sequence count");

    // every class fires
    start_run();
    nxt = 8'(SEED);
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < lens[s]; r++) begin
        int sp;
        logic [7:0] v;
        sp = G;
        v = nxt;
        if (s == 0 && r == 0) sp = G + M + 1;
        if (s == 0 && r == 1) sp = G - M - 1;
        if (s == 0 && r == 2) v = 8'hAA;
        if (r == lens[s] - 1) sp = (s == 3) ? 30 : IDLE + 20;
        send(v, 2, sp);
        nxt = nxt + 8'd1;
      end
    end
    end_run();
    check(int'(c_gap), 2, "R5 spacing one past each window edge");
    check(int'(c_data), 2, "R4 corrupt value and resync miss");
    check(int'(c_rec), 2, "R6 groups of seven and nine");
    check(int'(c_seq), 1, "R7 four groups against three, last closed by end");

    // R8 records after the run ends are ignored
    for (int i = 0; i < 3; i++) send(8'h00, 2, 5);
    repeat (20) @(negedge clk);
    check(int'(c_gap), 2, "R8 gap count held after end");
    check(int'(c_data), 2, "R8 data count held after end");

    // R9 saturation
    start_run();
    for (int i = 0; i < 40; i++) send(8'h55, 2, 10);
    repeat (30) @(negedge clk);
    end_run();
    check(int'(c_data), SAT, "R9 data counter saturates");
    check(int'(c_gap), SAT, "R9 gap counter saturates");
    check(int'(c_rec), 1, "R6 overlong group");
    check(int'(c_seq), 1, "R7 single group against three");

    chk_on = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule